// File: doc/BRIEF.md
# Message interface transfer controller

This block copies message descriptors between a host-visible staging register set and one entry of a message object memory. The staging set holds an acceptance mask group, an arbitration group (identifier, direction, extended flag, valid flag), a control word and eight data bytes. The host fills the staging registers through a simple write port and loads a command mask. Writing an object number to the command request register then starts a transfer of a fixed length. When the transfer ends, the controller copies the groups that the command mask selects, either from the staging set into the object or from the object into the staging set.

Each group has its own select bit, so the host can update or fetch part of an object and leave the rest alone. Two command bits act on the object's flags as a side effect of the transfer. On a store they set the transmit request. On a fetch they clear the pending-interrupt flag and the new-data flag, and the staging copy still shows the values the flags had before they were cleared. An object number outside the valid range is folded back into it instead of being refused.

Top module: `msgif_xfer`

## Requirements
- R1: A write to the command request register (address 0) while idle raises `busy` on the next clock. `busy` then stays high for exactly XFER_CYCLES (default 4) clocks and drops by itself. A read of address 0 returns `busy` in bit 15 and the written object number in bits 5:0.
- R2: Object numbers 1 to 32 address objects 1 to 32. Number 0 addresses object 32. Numbers 33 to 63 address objects 1 to 31, which is the number minus 32.
- R3: With command mask (address 1) bit 7 = 0, each selected group is copied from staging into the object when the transfer ends. Fields of groups that are not selected keep their earlier contents in the object.
- R4: With command mask bit 7 = 1, each selected group is copied from the object into staging. Staging fields of groups that are not selected keep their earlier contents.
- R5: The group select bits are: bit 6 for the mask group (addresses 2 and 3), bit 5 for the arbitration group (addresses 4 and 5), bit 4 for the control word (address 6), bit 1 for data bytes 0-3 (addresses 7 and 8) and bit 0 for data bytes 4-7 (addresses 9 and 10). Data address 7+k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R6: On a store (bit 7 = 0), command bit 2 sets the object's transmit request (control bit 8) even when the control word is not selected. Command bit 3 has no effect on a store.
- R7: On a fetch (bit 7 = 1), command bit 3 clears the object's interrupt-pending flag (control bit 13) and command bit 2 clears its new-data flag (control bit 15). The staging copy of the same transfer holds the values from before the clear.
- R8: While `busy` is high, writes to every register are ignored, including the command mask and the command request register, and a write to the command request register does not start a new transfer.
- R9: After reset, `busy` is low, all staging and command registers read 0 and all objects are 0. Address 3 holds mask-extended in bit 15, mask-direction in bit 14 and mask bits 28:16 in bits 12:0, and bit 13 reads 0. Address 5 holds valid in bit 15, extended in bit 14, direction in bit 13 and identifier bits 28:16 in bits 12:0. Addresses 2 and 4 hold bits 15:0 of the mask and of the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check the busy timing on every cycle: busy rises after a command, holds until its count runs out, and falls at the end. They also check that the staging and command registers stay frozen during a transfer, and that the transmit-request set and the interrupt-pending clear land in the addressed object. The bench scenarios cover the rest. These are the folding of all 64 object numbers onto the 32 objects, every combination of group selects in both directions with the unselected fields kept, the pre-clear values seen in staging, and the writes dropped while busy.

// File: rtl/msgif_pkg.sv
package msgif_pkg;

    // One message object; the staging register set has the same shape.
    typedef struct packed {
        logic [28:0] msk;
        logic        mxtd;
        logic        mdir;
        logic [28:0] id;
        logic        xtd;
        logic        dir;
        logic        valid;
        logic [15:0] ctrl;
        logic [63:0] data;
    } obj_t;

    // Control word flag positions
    localparam int CTL_NEWDAT = 15;
    localparam int CTL_INTPND = 13;
    localparam int CTL_TXRQST = 8;

    // Command mask bit positions
    localparam int CM_FETCH = 7;
    localparam int CM_MASK  = 6;
    localparam int CM_ARB   = 5;
    localparam int CM_CTRL  = 4;
    localparam int CM_FLAGA = 3;
    localparam int CM_FLAGB = 2;
    localparam int CM_DLO   = 1;
    localparam int CM_DHI   = 0;

    // Register addresses
    localparam logic [3:0] A_CMDREQ = 4'd0;
    localparam logic [3:0] A_CMDMSK = 4'd1;
    localparam logic [3:0] A_MSKLO  = 4'd2;
    localparam logic [3:0] A_MSKHI  = 4'd3;
    localparam logic [3:0] A_ARBLO  = 4'd4;
    localparam logic [3:0] A_ARBHI  = 4'd5;
    localparam logic [3:0] A_CTRL   = 4'd6;
    localparam logic [3:0] A_DATA0  = 4'd7;

endpackage

// File: rtl/msgif_objnum.sv
module msgif_objnum #(
    parameter int N_OBJ = 32,
    parameter int NUM_W = 6,
    parameter int IDX_W = 5
) (
    input  logic [NUM_W-1:0] num_i,
    output logic [IDX_W-1:0] idx_o
);
    // Fold the object number into the range 0..N_OBJ-1
    always_comb begin
        if (num_i == '0) begin
            idx_o = IDX_W'(N_OBJ - 1);
        end else begin
            idx_o = IDX_W'((32'(num_i) - 32'd1) % N_OBJ);
        end
    end
endmodule

// File: rtl/msgif_objmem.sv
module msgif_objmem
    import msgif_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  obj_t             wdata_i,
    output obj_t             rdata_o
);
    obj_t rd_arr [N_OBJ];

    genvar g;
    generate
        for (g = 0; g < N_OBJ; g++) begin : g_ent
            obj_t ent_d, ent_q;
            always_comb begin
                ent_d = ent_q;
                if (we_i && idx_i == IDX_W'(g)) ent_d = wdata_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q <= '0;
                else        ent_q <= ent_d;
            end
            assign rd_arr[g] = ent_q;
        end
    endgenerate

    assign rdata_o = rd_arr[idx_i];
endmodule

// File: rtl/msgif_merge.sv
module msgif_merge
    import msgif_pkg::*;
(
    input  logic [7:0] cm_i,
    input  obj_t       stg_i,
    input  obj_t       obj_i,
    output obj_t       stg_o,
    output obj_t       obj_o
);
    always_comb begin
        stg_o = stg_i;
        obj_o = obj_i;
        if (!cm_i[CM_FETCH]) begin
            if (cm_i[CM_MASK]) begin
                obj_o.msk  = stg_i.msk;
                obj_o.mxtd = stg_i.mxtd;
                obj_o.mdir = stg_i.mdir;
            end
            if (cm_i[CM_ARB]) begin
                obj_o.id    = stg_i.id;
                obj_o.xtd   = stg_i.xtd;
                obj_o.dir   = stg_i.dir;
                obj_o.valid = stg_i.valid;
            end
            if (cm_i[CM_CTRL]) obj_o.ctrl         = stg_i.ctrl;
            if (cm_i[CM_DLO])  obj_o.data[31:0]   = stg_i.data[31:0];
            if (cm_i[CM_DHI])  obj_o.data[63:32]  = stg_i.data[63:32];
            if (cm_i[CM_FLAGB]) obj_o.ctrl[CTL_TXRQST] = 1'b1;
        end else begin
            if (cm_i[CM_MASK]) begin
                stg_o.msk  = obj_i.msk;
                stg_o.mxtd = obj_i.mxtd;
                stg_o.mdir = obj_i.mdir;
            end
            if (cm_i[CM_ARB]) begin
                stg_o.id    = obj_i.id;
                stg_o.xtd   = obj_i.xtd;
                stg_o.dir   = obj_i.dir;
                stg_o.valid = obj_i.valid;
            end
            if (cm_i[CM_CTRL]) stg_o.ctrl         = obj_i.ctrl;
            if (cm_i[CM_DLO])  stg_o.data[31:0]   = obj_i.data[31:0];
            if (cm_i[CM_DHI])  stg_o.data[63:32]  = obj_i.data[63:32];
            if (cm_i[CM_FLAGA]) obj_o.ctrl[CTL_INTPND] = 1'b0;
            if (cm_i[CM_FLAGB]) obj_o.ctrl[CTL_NEWDAT] = 1'b0;
        end
    end
endmodule

// File: rtl/msgif_xfer.sv
module msgif_xfer
    import msgif_pkg::*;
#(
    parameter int N_OBJ       = 32,
    parameter int XFER_CYCLES = 4,
    parameter int NUM_W       = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        busy
);
    localparam int IDX_W = $clog2(N_OBJ);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] num;
        logic [7:0]       cm;
        obj_t             stg;
    } ctl_t;

    ctl_t s_d, s_q;
    logic [IDX_W-1:0] idx;
    obj_t obj_rd, obj_new, stg_new;
    logic done;

    assign done = s_q.busy && (s_q.cnt == '0);
    assign busy = s_q.busy;

    msgif_objnum #(.N_OBJ(N_OBJ), .NUM_W(NUM_W), .IDX_W(IDX_W)) u_num (
        .num_i (s_q.num),
        .idx_o (idx)
    );

    msgif_objmem #(.N_OBJ(N_OBJ), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (done),
        .idx_i   (idx),
        .wdata_i (obj_new),
        .rdata_o (obj_rd)
    );

    msgif_merge u_mrg (
        .cm_i  (s_q.cm),
        .stg_i (s_q.stg),
        .obj_i (obj_rd),
        .stg_o (stg_new),
        .obj_o (obj_new)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (done) begin
                s_d.busy = 1'b0;
                s_d.stg  = stg_new;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (wr_en) begin
            case (wr_addr)
                A_CMDREQ: begin
                    s_d.num  = wr_data[NUM_W-1:0];
                    s_d.busy = 1'b1;
                    s_d.cnt  = CNT_W'(XFER_CYCLES - 1);
                end
                A_CMDMSK: s_d.cm = wr_data[7:0];
                A_MSKLO:  s_d.stg.msk[15:0] = wr_data;
                A_MSKHI: begin
                    s_d.stg.mxtd        = wr_data[15];
                    s_d.stg.mdir        = wr_data[14];
                    s_d.stg.msk[28:16]  = wr_data[12:0];
                end
                A_ARBLO:  s_d.stg.id[15:0] = wr_data;
                A_ARBHI: begin
                    s_d.stg.valid      = wr_data[15];
                    s_d.stg.xtd        = wr_data[14];
                    s_d.stg.dir        = wr_data[13];
                    s_d.stg.id[28:16]  = wr_data[12:0];
                end
                A_CTRL:   s_d.stg.ctrl = wr_data;
                default: begin
                    for (int i = 0; i < 4; i++) begin
                        if (wr_addr == A_DATA0 + 4'(i)) s_d.stg.data[16*i +: 16] = wr_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMDREQ: rd_data = {s_q.busy, {(15-NUM_W){1'b0}}, s_q.num};
            A_CMDMSK: rd_data = {8'h00, s_q.cm};
            A_MSKLO:  rd_data = s_q.stg.msk[15:0];
            A_MSKHI:  rd_data = {s_q.stg.mxtd, s_q.stg.mdir, 1'b0, s_q.stg.msk[28:16]};
            A_ARBLO:  rd_data = s_q.stg.id[15:0];
            A_ARBHI:  rd_data = {s_q.stg.valid, s_q.stg.xtd, s_q.stg.dir, s_q.stg.id[28:16]};
            A_CTRL:   rd_data = s_q.stg.ctrl;
            default: begin
                for (int i = 0; i < 4; i++) begin
                    if (rd_addr == A_DATA0 + 4'(i)) rd_data = s_q.stg.data[16*i +: 16];
                end
            end
        endcase
    end

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMDREQ && !busy) |=> busy);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> busy);

    // R1
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    stage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> ($stable(s_q.stg) && $stable(s_q.cm) && $stable(s_q.num)));

    // R6
    txrqst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !s_q.cm[CM_FETCH] && s_q.cm[CM_FLAGB]) |=> obj_rd.ctrl[CTL_TXRQST]);

    // R7
    intpnd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.cm[CM_FETCH] && s_q.cm[CM_FLAGA]) |=> !obj_rd.ctrl[CTL_INTPND]);

endmodule

// File: tb/sim_msgif_xfer.sv
module sim_msgif_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    wire  [15:0] rd_data;
    wire         busy;

    msgif_xfer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [15:0] sw [9];
    logic [15:0] ow [32][9];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int grp(input int w);
        if (w < 2) return 6;
        if (w < 4) return 5;
        if (w == 4) return 4;
        if (w < 7) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] pat(input int seed, input int w);
        logic [15:0] v;
        v = 16'((seed * 40503 + w * 15467) ^ (seed << 5) ^ (w << 11));
        if (w == 1) v[13] = 1'b0;
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic load_stg(input int seed);
        for (int w = 0; w < 9; w++) begin
            sw[w] = pat(seed, w);
            wr(4'(2 + w), sw[w]);
        end
    endtask

    task automatic xfer(input int num, input logic [7:0] cm);
        int n;
        int idx;
        wr(4'd1, {8'h00, cm});
        wr(4'd0, 16'(num));
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk("R1 busy length", 16'(n), 16'd4);
        idx = (num == 0) ? 31 : (num - 1) % 32;
        if (!cm[7]) begin
            for (int w = 0; w < 9; w++) if (cm[grp(w)]) ow[idx][w] = sw[w];
            if (cm[2]) ow[idx][4] = ow[idx][4] | 16'h0100;
        end else begin
            for (int w = 0; w < 9; w++) if (cm[grp(w)]) sw[w] = ow[idx][w];
            if (cm[3]) ow[idx][4] = ow[idx][4] & ~16'h2000;
            if (cm[2]) ow[idx][4] = ow[idx][4] & ~16'h8000;
        end
    endtask

    task automatic cmp_stg(input string tag);
        logic [15:0] v;
        for (int w = 0; w < 9; w++) begin
            rd(4'(2 + w), v);
            chk(tag, v, sw[w]);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 32; i++) for (int w = 0; w < 9; w++) ow[i][w] = '0;
        for (int w = 0; w < 9; w++) sw[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values of every register
        chk("R9 busy after reset", {15'd0, busy}, 16'd0);
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            chk("R9 reset register", v, 16'h0000);
        end

        // R3: store a distinct full pattern into every object
        for (int n = 1; n <= 32; n++) begin
            load_stg(n);
            xfer(n, 8'h73);
        end

        // R2: fetch with all 64 raw numbers, folding onto the objects
        for (int n = 0; n < 64; n++) begin
            load_stg(500 + n);
            xfer(n, 8'hF3);
            cmp_stg("R2 object number fold");
        end

        // R3 / R5: every store group selection on object 7, then fetch all
        for (int s = 0; s < 32; s++) begin
            logic [7:0] cm;
            cm = {1'b0, 1'(s >> 4), 1'(s >> 3), 1'(s >> 2), 2'b00, 1'(s >> 1), 1'(s)};
            load_stg(100 + s);
            xfer(7, cm);
            load_stg(700 + s);
            xfer(7, 8'hF3);
            cmp_stg("R3 R5 store group select");
        end

        // R4 / R5: every fetch group selection from object 9
        for (int s = 0; s < 32; s++) begin
            logic [7:0] cm;
            cm = {1'b1, 1'(s >> 4), 1'(s >> 3), 1'(s >> 2), 2'b00, 1'(s >> 1), 1'(s)};
            load_stg(200 + s);
            xfer(9, cm);
            cmp_stg("R4 R5 fetch group select");
        end

        // R6: transmit request set on store, bit 3 ignored on store
        load_stg(40);
        wr(4'd6, 16'h2405); sw[4] = 16'h2405;
        xfer(12, 8'h10);
        load_stg(41);
        xfer(12, 8'h08);
        xfer(12, 8'hF3);
        cmp_stg("R6 bit3 ignored on store");
        load_stg(42);
        xfer(12, 8'h04);
        xfer(12, 8'hF3);
        cmp_stg("R6 txrqst set");
        chk("R6 txrqst bit", sw[4] & 16'h0100, 16'h0100);

        // R7: flags cleared after the copy
        load_stg(50);
        wr(4'd6, 16'hA108); sw[4] = 16'hA108;
        xfer(14, 8'h10);
        load_stg(51);
        xfer(14, 8'h9C);
        cmp_stg("R7 pre-clear copy");
        chk("R7 staging flags", sw[4], 16'hA108);
        xfer(14, 8'hF3);
        cmp_stg("R7 flags cleared");
        chk("R7 cleared control", sw[4], 16'h0108);

        // R8: writes ignored while busy
        load_stg(60);
        wr(4'd1, 16'h0080);
        wr(4'd0, 16'd5);
        rd_addr = 4'd0;
        #1 chk("R1 status while busy", rd_data, 16'h8005);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_addr = 4'd0; wr_data = 16'd20;
        @(negedge clk);
        wr_addr = 4'd1; wr_data = 16'h0073;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 busy after ignored writes", {15'd0, busy}, 16'd0);
        @(negedge clk);
        chk("R8 no retrigger", {15'd0, busy}, 16'd0);
        rd(4'd7, v);
        chk("R8 data ignored", v, sw[5]);
        rd(4'd0, v);
        chk("R8 number kept", v, 16'h0005);
        rd(4'd1, v);
        chk("R8 mask kept", v, 16'h0080);

        finish_run();
    end
endmodule